// File: doc/BRIEF.md
# Transmit Timeout Guard

This block keeps a half-duplex line interface from being stranded in transmit mode. Software selects transmit or receive through a mode bit. While transmit is selected, a 13-bit down-counter loses one count on each prescaler tick. If it runs out, the block clears the mode bit by force, which returns the interface to receive, the normal idle state. It also raises a sticky timeout flag.

Software that needs a long transmission keeps it going by writing a fixed key byte to a kick register before the count runs out. Any other byte written there does nothing. The counter also reloads each time the interface moves from receive to transmit, so every transmit burst starts with the full budget. While the interface receives, the counter is frozen.

Control goes through a small write-only register port with three addresses. The mode bit and the timeout flag come out as direct outputs.

Top module: `tx_timeout_guard`

## Requirements
- R1: After a move into transmit, exactly 8191 ticks with no kick pass before the forced return to receive. The guard counter is 13 bits wide and reloads to all ones.
- R2: The counter changes only on a clock where `tick_i` is 1 while in transmit. Ticks during receive, and clocks without a tick, never cause a timeout.
- R3: At the clock edge that takes the final tick, `tx_mode_o` falls to 0 and `timeout_o` rises to 1.
- R4: Writing 0xA2 to address 1 (kick register) reloads the counter to 8191, so a further 8191 ticks are needed before expiry.
- R5: A write to address 1 with any value other than 0xA2 is ignored. The pending expiry is unchanged.
- R6: Address 0 holds the mode in bit 0: 1 means transmit and 0 means receive. Both outputs reset to 0. A write that moves the mode from 0 to 1 reloads the counter to 8191.
- R7: The timeout flag is sticky. Writing a byte with bit 0 = 1 to address 2 clears it. A byte with bit 0 = 0 leaves it set.
- R8: A mode write of 1 in the same clock as the final tick loses: the interface goes to receive.
- R9: A flag-clear write in the same clock as the final tick loses: the flag ends set.
- R10: A valid kick in the same clock as the final tick wins: no expiry occurs and the counter reloads to 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 kick, 2 flag clear |
| wr_data_i | input | 8 | Register write data |
| tx_mode_o | output | 1 | 1 = transmit, 0 = receive |
| timeout_o | output | 1 | Sticky flag, set when transmit was forced off |

## Verification
Three software actions can land in the same clock as the expiring tick: a mode write of 1, a flag-clear write, and a kick. The bench brings the counter to one remaining count, then drives the final tick together with each of these writes in turn.
- For the mode write, the mode must end at receive with the flag set.
- For the flag-clear write, the flag must end set.
- For the kick, the mode must stay at transmit. The run then has to last another full 8191 ticks before expiry.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;

  // Decoded one-cycle write requests from the register port.
  typedef struct packed {
    logic mode_wr;   // write to the mode register
    logic mode_val;  // value of bit 0 written to the mode register
    logic kick;      // valid key written to the kick register
    logic flag_clr;  // request to clear the sticky timeout flag
  } tg_req_t;

  localparam int unsigned TG_ADDR_W = 2;
  localparam int unsigned TG_DATA_W = 8;

  localparam logic [TG_ADDR_W-1:0] TG_ADDR_MODE = 2'd0;
  localparam logic [TG_ADDR_W-1:0] TG_ADDR_KICK = 2'd1;
  localparam logic [TG_ADDR_W-1:0] TG_ADDR_FLAG = 2'd2;

  localparam logic [TG_DATA_W-1:0] TG_KEY = 8'hA2;

endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tx_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = TG_ADDR_W,
  parameter int unsigned DATA_W = TG_DATA_W,
  parameter logic [ADDR_W-1:0] A_MODE = TG_ADDR_MODE,
  parameter logic [ADDR_W-1:0] A_KICK = TG_ADDR_KICK,
  parameter logic [ADDR_W-1:0] A_FLAG = TG_ADDR_FLAG,
  parameter logic [DATA_W-1:0] KEY    = TG_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output tg_req_t           req_o
);

  logic hit_mode, hit_kick, hit_flag;

  always_comb begin
    hit_mode = wr_en_i && (wr_addr_i == A_MODE);
    hit_kick = wr_en_i && (wr_addr_i == A_KICK);
    hit_flag = wr_en_i && (wr_addr_i == A_FLAG);

    req_o          = '0;
    req_o.mode_wr  = hit_mode;
    req_o.mode_val = hit_mode && wr_data_i[0];
    req_o.kick     = hit_kick && (wr_data_i == KEY);
    req_o.flag_clr = hit_flag && wr_data_i[0];
  end

  // R5: a kick-register write whose data is not the key must not kick
  assert_bad_key_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_kick && (wr_data_i != KEY)) |-> !req_o.kick);

  // At most one register is addressed per write
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_o.mode_wr, req_o.kick, req_o.flag_clr}));

endmodule

// File: rtl/tg_counter.sv
module tg_counter
  import tx_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic tx_mode_i,   // current mode register value
  input  logic tx_enter_i,  // receive-to-transmit write this cycle
  input  logic kick_i,      // valid key written this cycle
  output logic expire_o     // final tick consumed this cycle
);

  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reload, step, cnt_en;

  always_comb begin
    reload   = kick_i || tx_enter_i;
    step     = tx_mode_i && tick_i && !reload;
    expire_o = step && (cnt_q <= CNT_ONE);
    cnt_en   = reload || (step && (cnt_q != '0));
    cnt_d    = reload ? CNT_FULL : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_FULL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4/R6: any reload sets the full budget
  assert_reload_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == CNT_FULL));

  // R2: in receive without a reload, the counter is frozen
  assert_hold_in_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode_i && !reload) |=> $stable(cnt_q));

  // R2: without a tick and without a reload, nothing moves
  assert_no_tick_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reload) |=> $stable(cnt_q));

  // R10: a kick in the cycle of the last tick prevents expiry
  assert_kick_beats_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |-> !expire_o);

endmodule

// File: rtl/tg_mode_ctrl.sv
module tg_mode_ctrl
  import tx_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tg_req_t req_i,
  input  logic    expire_i,
  output logic    tx_mode_o,
  output logic    tx_enter_o,
  output logic    timeout_o
);

  logic mode_q, mode_d, mode_en;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    tx_enter_o = req_i.mode_wr && req_i.mode_val && !mode_q;

    // forced receive has priority over a software write
    mode_en = expire_i || req_i.mode_wr;
    mode_d  = expire_i ? 1'b0 : req_i.mode_val;

    // setting the flag has priority over clearing it
    flag_en = expire_i || req_i.flag_clr;
    flag_d  = expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign tx_mode_o = mode_q;
  assign timeout_o = flag_q;

  // R3: expiry returns the interface to receive and raises the flag
  assert_expire_to_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (!mode_q && flag_q));

  // R8: a concurrent mode write of 1 cannot keep transmit alive
  assert_forced_rx_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && req_i.mode_wr && req_i.mode_val) |=> !mode_q);

  // R7: the flag stays set until cleared
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !req_i.flag_clr) |=> flag_q);

  // R9: a clear in the expiry cycle loses
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && req_i.flag_clr) |=> flag_q);

  // Expiry can only happen while transmitting
  assert_expire_only_in_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |-> mode_q);

endmodule

// File: rtl/tx_timeout_guard.sv
module tx_timeout_guard
  import tx_guard_pkg::*;
#(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned ADDR_W = TG_ADDR_W,
  parameter int unsigned DATA_W = TG_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_mode_o,
  output logic              timeout_o
);

  tg_req_t req;
  logic    expire, tx_enter, tx_mode;

  tg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .req_o     (req)
  );

  tg_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .tx_mode_i  (tx_mode),
    .tx_enter_i (tx_enter),
    .kick_i     (req.kick),
    .expire_o   (expire)
  );

  tg_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .expire_i   (expire),
    .tx_mode_o  (tx_mode),
    .tx_enter_o (tx_enter),
    .timeout_o  (timeout_o)
  );

  assign tx_mode_o = tx_mode;

  // R3: transmit can only end by a software write or by expiry
  assert_tx_exit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_mode_o) |-> ($past(req.mode_wr) || $rose(timeout_o) || timeout_o));

endmodule

// File: tb/sim_tx_timeout_guard.sv
module sim_tx_timeout_guard;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       tx_mode, timeout;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  localparam int FULL = 8191;

  always #4 clk = ~clk;  // 125 MHz

  tx_timeout_guard u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .tx_mode_o (tx_mode),
    .timeout_o (timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tick_with_wr(input logic [1:0] a, input logic [7:0] d);
    tick = 1'b1;
    wr(a, d);
    tick = 1'b0;
  endtask

  task automatic clear_all;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_reset;
    chk(tx_mode == 1'b0, "R6 reset mode", tx_mode, 0);
    chk(timeout == 1'b0, "R6 reset flag", timeout, 0);
  endtask

  task automatic t_full_budget;
    clear_all();
    wr(2'd0, 8'h01);
    chk(tx_mode == 1'b1, "R6 enter transmit", tx_mode, 1);
    ticks(FULL - 1);
    chk(tx_mode == 1'b1, "R1 alive one tick before expiry", tx_mode, 1);
    chk(timeout == 1'b0, "R1 no flag before expiry", timeout, 0);
    ticks(1);
    chk(tx_mode == 1'b0, "R3 forced receive", tx_mode, 0);
    chk(timeout == 1'b1, "R3 flag set", timeout, 1);
  endtask

  task automatic t_flag_clear;
    wr(2'd2, 8'h00);
    chk(timeout == 1'b1, "R7 bit0=0 keeps flag", timeout, 1);
    wr(2'd2, 8'h01);
    chk(timeout == 1'b0, "R7 bit0=1 clears flag", timeout, 0);
  endtask

  task automatic t_kick;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(5000);
    wr(2'd1, 8'hA2);
    ticks(FULL - 1);
    chk(tx_mode == 1'b1, "R4 kick extends budget", tx_mode, 1);
    ticks(1);
    chk(tx_mode == 1'b0, "R4 expiry after kick", tx_mode, 0);
  endtask

  task automatic t_bad_key;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(5000);
    wr(2'd1, 8'hA3);
    wr(2'd1, 8'h00);
    ticks(FULL - 5000 - 1);
    chk(tx_mode == 1'b1, "R5 still alive", tx_mode, 1);
    ticks(1);
    chk(tx_mode == 1'b0, "R5 wrong key ignored", tx_mode, 0);
  endtask

  task automatic t_rx_hold;
    clear_all();
    ticks(10000);
    chk(tx_mode == 1'b0, "R2 receive ignores ticks mode", tx_mode, 0);
    chk(timeout == 1'b0, "R2 receive ignores ticks flag", timeout, 0);
    wr(2'd0, 8'h01);
    repeat (1000) @(negedge clk);
    chk(tx_mode == 1'b1, "R2 clocks without tick", tx_mode, 1);
  endtask

  task automatic t_reentry;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(4000);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    ticks(FULL - 1);
    chk(tx_mode == 1'b1, "R6 re-entry reloads", tx_mode, 1);
    ticks(1);
    chk(tx_mode == 1'b0, "R6 expiry after re-entry", tx_mode, 0);
  endtask

  task automatic t_mode_race;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(FULL - 1);
    tick_with_wr(2'd0, 8'h01);
    chk(tx_mode == 1'b0, "R8 forced receive wins", tx_mode, 0);
    chk(timeout == 1'b1, "R8 flag set", timeout, 1);
  endtask

  task automatic t_flag_race;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(FULL - 1);
    tick_with_wr(2'd2, 8'h01);
    chk(timeout == 1'b1, "R9 set beats clear", timeout, 1);
  endtask

  task automatic t_kick_race;
    clear_all();
    wr(2'd0, 8'h01);
    ticks(FULL - 1);
    tick_with_wr(2'd1, 8'hA2);
    chk(tx_mode == 1'b1, "R10 kick wins mode", tx_mode, 1);
    chk(timeout == 1'b0, "R10 kick wins flag", timeout, 0);
    ticks(FULL - 1);
    chk(tx_mode == 1'b1, "R10 full reload", tx_mode, 1);
    ticks(1);
    chk(tx_mode == 1'b0, "R10 expiry after reload", tx_mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_budget();
    t_flag_clear();
    t_kick();
    t_bad_key();
    t_rx_hold();
    t_reentry();
    t_mode_race();
    t_flag_race();
    t_kick_race();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule